// File: doc/BRIEF.md
# Video Controller CPU Register Front End with Reset Warmup

This block is the processor-facing register set of a tile-based video controller. It decodes eight byte-wide registers, mirrored across the whole decoded address window. Through them the processor reaches the control and mask bytes, the status flags, the sprite-memory address and data port, the scroll and VRAM-address ports, and the VRAM data port. The VRAM data port has a one-read delay buffer. The block holds the current VRAM address (V), the temporary address (T), the three fine horizontal scroll bits and the toggle that the scroll and address ports share. Sprite memory, video memory and frame timing sit outside the block. They connect through plain ports: the frame-timing unit pulses the start and end of the vertical blank, sprite-0 hit and sprite overflow.

Power-up and console reset behave differently. Either one arms an internal warmup flag, and only the end-of-blank pulse clears it. While the flag is armed, writes to the control, mask, scroll and VRAM-address registers are dropped and the shared toggle holds its value. The status, sprite and data ports keep working. Console reset keeps V, the sprite address and the status flags. A warm power-up, used when the supply was only briefly removed, starts from a distinct set of values.

Top module: `vreg_front`

## Requirements
- R1: While `pwr_up` is high with `warm` low, the following take these values: control, mask, T, fine X, the toggle, the read buffer, V and the sprite address all become zero; the blank flag takes `vbl_seed`; the sprite-0 and overflow flags clear.
- R2: While `pwr_up` is high with `warm` high, the block loads these values: `status_q` becomes 0x80, V becomes 0x0001 and the sprite address becomes the parameter WARM_OAM_ADDR (default 0x2F). Control, mask, T, fine X, the toggle and the buffer clear as in R1.
- R3: A console reset (`rst`) clears control, mask, T, fine X, the toggle and the read buffer. It leaves V, the sprite address and all three status flags unchanged.
- R4: Power-up and reset arm the warmup flag, and only `ev_vbl_end` clears it. While it is armed, writes to indices 0, 1, 5 and 6 change nothing and the toggle holds. A write in the same cycle as `ev_vbl_end` is still dropped.
- R5: While the warmup flag is armed, status reads, sprite-address writes, sprite-data accesses and data-port accesses behave normally.
- R6: A status read (index 2) returns the blank, sprite-0 and overflow flags in bits 7, 6 and 5, with bits 4:0 zero. It then clears the blank flag and the toggle. `ev_vbl_start` sets the blank flag, and `ev_spr0` and `ev_ovf` set their own flags. `ev_vbl_end` clears all three flags; when a set pulse arrives in the same cycle, the set wins.
- R7: The scroll port (index 5) behaves as follows. With the toggle clear, a write loads T[4:0] from data[7:3] and fine X from data[2:0]. With the toggle set, a write loads T[14:12] from data[2:0] and T[9:5] from data[7:3]. Every accepted write flips the toggle.
- R8: The VRAM-address port (index 6) behaves as follows. With the toggle clear, a write loads T[13:8] from data[5:0] and clears T[14]. With the toggle set, a write loads T[7:0] and then copies the new T into V. Every accepted write flips the toggle.
- R9: A write to index 0 stores the control byte and loads T[11:10] from data[1:0]. A write to index 1 stores the mask byte.
- R10: A data-port read (index 7) returns the buffer's previous contents and loads the buffer from `vram_rdata`, which is the byte at V.
- R11: Every data-port access adds to V: 1 when control bit 2 is clear, 32 when it is set. A data-port write drives `vram_we` high for that cycle, with `vram_wdata` equal to the written byte.
- R12: A sprite-data write (index 4) drives `oam_we` and `oam_wdata` and then increments the sprite address. A sprite-data read returns `oam_rdata` and leaves the address unchanged. A write to index 3 loads the sprite address.
- R13: Only bus address bits 2:0 select the register: 0 control, 1 mask, 2 status, 3 sprite address, 4 sprite data, 5 scroll, 6 VRAM address, 7 data. Reads of indices 0, 1, 3, 5 and 6 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_up | input | 1 | Power-up reset, synchronous, active high |
| warm | input | 1 | Selects warm power-up values while pwr_up is high |
| vbl_seed | input | 1 | Blank flag value loaded at cold power-up |
| rst | input | 1 | Console reset, synchronous, active high |
| bus_addr | input | BUS_AW | Processor address; bits 2:0 select the register |
| bus_wdata | input | 8 | Processor write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| ev_vbl_start | input | 1 | Pulse at the start of vertical blank |
| ev_vbl_end | input | 1 | Pulse at the end of vertical blank |
| ev_spr0 | input | 1 | Sprite-0 hit pulse |
| ev_ovf | input | 1 | Sprite overflow pulse |
| oam_addr_q | output | 8 | Sprite memory address |
| oam_we | output | 1 | Sprite memory write enable |
| oam_wdata | output | 8 | Sprite memory write data |
| oam_rdata | input | 8 | Sprite memory byte at oam_addr_q |
| vram_we | output | 1 | Video memory write enable, address v_addr |
| vram_wdata | output | 8 | Video memory write data |
| vram_rdata | input | 8 | Video memory byte at v_addr |
| ctrl_q | output | 8 | Control register |
| mask_q | output | 8 | Mask register |
| status_q | output | 8 | Status byte as a read would return it |
| v_addr | output | 15 | Current VRAM address V |
| t_addr | output | 15 | Temporary VRAM address T |
| fine_x | output | 3 | Fine horizontal scroll |

## Verification
The bound checker watches these rules on every cycle:
- A dropped write to a guarded register leaves control, T and fine X unchanged.
- Reset clears its set of fields, keeps V and the sprite address, and arms the warmup flag.
- The flag stays armed until the end-of-blank pulse.
- A status read or an end-of-blank pulse clears the flags it should.
- Each data-port read steps V by the stride that control bit 2 selects.

Some behaviour shows only in the bench's sequences. The toggle holding through a blocked write is visible only in the address a later pair of writes builds. The one-read lag of the buffer needs several reads in a row to show. The difference between a cold and a warm power-up, and the mirroring of the register index, also come only from the scenarios.

// File: rtl/vreg_pkg.sv
package vreg_pkg;

   localparam int DW   = 8;
   localparam int VA_W = 15;
   localparam int IX_W = 3;
   localparam int N_IX = 1 << IX_W;

   typedef enum logic [IX_W-1:0] {
      IX_CTRL  = 3'd0,
      IX_MASK  = 3'd1,
      IX_STAT  = 3'd2,
      IX_OADR  = 3'd3,
      IX_ODAT  = 3'd4,
      IX_SCRL  = 3'd5,
      IX_VADR  = 3'd6,
      IX_VDAT  = 3'd7
   } reg_ix_e;

   typedef struct packed {
      logic vbl;
      logic spr0;
      logic ovf;
   } stat_t;

endpackage

// File: rtl/vreg_decode.sv
module vreg_decode
   import vreg_pkg::*;
(
   input  logic [IX_W-1:0] ix,
   input  logic            wr,
   input  logic            rd,
   output logic [N_IX-1:0] wr_hit,
   output logic [N_IX-1:0] rd_hit
);

   for (genvar g = 0; g < N_IX; g++) begin : g_hit
      assign wr_hit[g] = wr && (ix == IX_W'(g));
      assign rd_hit[g] = rd && (ix == IX_W'(g));
   end

endmodule

// File: rtl/vreg_status.sv
module vreg_status
   import vreg_pkg::*;
(
   input  logic  clk,
   input  logic  pwr_up,
   input  logic  warm,
   input  logic  vbl_seed,
   input  logic  rst,
   input  logic  rd_stat,
   input  logic  ev_vbl_start,
   input  logic  ev_vbl_end,
   input  logic  ev_spr0,
   input  logic  ev_ovf,
   output stat_t flags,
   output logic  blk
);

   always_ff @(posedge clk) begin
      if (pwr_up) begin
         flags.vbl  <= warm ? 1'b1 : vbl_seed;
         flags.spr0 <= 1'b0;
         flags.ovf  <= 1'b0;
         blk        <= 1'b1;
      end else if (rst) begin
         blk        <= 1'b1;
      end else begin
         if (ev_vbl_start)
            flags.vbl <= 1'b1;
         else if (ev_vbl_end || rd_stat)
            flags.vbl <= 1'b0;

         if (ev_spr0)
            flags.spr0 <= 1'b1;
         else if (ev_vbl_end)
            flags.spr0 <= 1'b0;

         if (ev_ovf)
            flags.ovf <= 1'b1;
         else if (ev_vbl_end)
            flags.ovf <= 1'b0;

         if (ev_vbl_end)
            blk <= 1'b0;
      end
   end

endmodule

// File: rtl/vreg_addr.sv
module vreg_addr
   import vreg_pkg::*;
#(
   parameter int ROW_STRIDE = 32
) (
   input  logic            clk,
   input  logic            pwr_up,
   input  logic            warm,
   input  logic            rst,
   input  logic            blk,
   input  logic            wr_ctrl,
   input  logic            wr_scrl,
   input  logic            wr_vadr,
   input  logic            rd_stat,
   input  logic            data_acc,
   input  logic            big_step,
   input  logic [DW-1:0]   d,
   output logic [VA_W-1:0] v,
   output logic [VA_W-1:0] t,
   output logic [2:0]      fx
);

   localparam logic [VA_W-1:0] STEP_ROW = VA_W'(ROW_STRIDE);
   localparam logic [VA_W-1:0] STEP_ONE = VA_W'(1);

   logic            tog;
   logic            ok_ctrl, ok_scrl, ok_vadr;
   logic [VA_W-1:0] step;

   assign ok_ctrl = wr_ctrl && !blk;
   assign ok_scrl = wr_scrl && !blk;
   assign ok_vadr = wr_vadr && !blk;
   assign step    = big_step ? STEP_ROW : STEP_ONE;

   always_ff @(posedge clk) begin
      if (pwr_up) begin
         v   <= warm ? VA_W'(1) : '0;
         t   <= '0;
         fx  <= '0;
         tog <= 1'b0;
      end else if (rst) begin
         t   <= '0;
         fx  <= '0;
         tog <= 1'b0;
      end else begin
         if (ok_ctrl)
            t[11:10] <= d[1:0];

         if (ok_scrl) begin
            if (!tog) begin
               t[4:0] <= d[7:3];
               fx     <= d[2:0];
            end else begin
               t[14:12] <= d[2:0];
               t[9:5]   <= d[7:3];
            end
            tog <= ~tog;
         end

         if (ok_vadr) begin
            if (!tog) begin
               t[13:8] <= d[5:0];
               t[14]   <= 1'b0;
            end else begin
               t[7:0] <= d;
               v      <= {t[14:8], d};
            end
            tog <= ~tog;
         end

         if (data_acc)
            v <= v + step;

         if (rd_stat)
            tog <= 1'b0;
      end
   end

endmodule

// File: rtl/vreg_front.sv
module vreg_front
   import vreg_pkg::*;
#(
   parameter int          BUS_AW        = 13,
   parameter int          ROW_STRIDE    = 32,
   parameter logic [7:0]  WARM_OAM_ADDR = 8'h2F
) (
   input  logic              clk,
   input  logic              pwr_up,
   input  logic              warm,
   input  logic              vbl_seed,
   input  logic              rst,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [7:0]        bus_rdata,
   input  logic              ev_vbl_start,
   input  logic              ev_vbl_end,
   input  logic              ev_spr0,
   input  logic              ev_ovf,
   output logic [7:0]        oam_addr_q,
   output logic              oam_we,
   output logic [7:0]        oam_wdata,
   input  logic [7:0]        oam_rdata,
   output logic              vram_we,
   output logic [7:0]        vram_wdata,
   input  logic [7:0]        vram_rdata,
   output logic [7:0]        ctrl_q,
   output logic [7:0]        mask_q,
   output logic [7:0]        status_q,
   output logic [14:0]       v_addr,
   output logic [14:0]       t_addr,
   output logic [2:0]        fine_x
);

   if (BUS_AW < IX_W) begin : g_bad_aw
      $error("vreg_front: BUS_AW must cover the register index");
   end
   if (ROW_STRIDE < 2 || ROW_STRIDE >= (1 << VA_W)) begin : g_bad_stride
      $error("vreg_front: ROW_STRIDE out of range");
   end

   logic [IX_W-1:0] ix;
   logic [N_IX-1:0] wr_hit, rd_hit;
   logic            warm_blk;
   stat_t           flags;
   logic [DW-1:0]   rbuf;
   logic            data_acc;

   assign ix = bus_addr[IX_W-1:0];

   if (BUS_AW > IX_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^bus_addr[BUS_AW-1:IX_W];
   end

   logic unused_hits;
   assign unused_hits = ^{rd_hit[IX_CTRL], rd_hit[IX_MASK], rd_hit[IX_OADR],
                          rd_hit[IX_SCRL], rd_hit[IX_VADR], wr_hit[IX_STAT]};

   vreg_decode u_dec (
      .ix     (ix),
      .wr     (bus_wr),
      .rd     (bus_rd),
      .wr_hit (wr_hit),
      .rd_hit (rd_hit)
   );

   vreg_status u_stat (
      .clk          (clk),
      .pwr_up       (pwr_up),
      .warm         (warm),
      .vbl_seed     (vbl_seed),
      .rst          (rst),
      .rd_stat      (rd_hit[IX_STAT]),
      .ev_vbl_start (ev_vbl_start),
      .ev_vbl_end   (ev_vbl_end),
      .ev_spr0      (ev_spr0),
      .ev_ovf       (ev_ovf),
      .flags        (flags),
      .blk          (warm_blk)
   );

   assign data_acc = wr_hit[IX_VDAT] || rd_hit[IX_VDAT];

   vreg_addr #(.ROW_STRIDE(ROW_STRIDE)) u_addr (
      .clk      (clk),
      .pwr_up   (pwr_up),
      .warm     (warm),
      .rst      (rst),
      .blk      (warm_blk),
      .wr_ctrl  (wr_hit[IX_CTRL]),
      .wr_scrl  (wr_hit[IX_SCRL]),
      .wr_vadr  (wr_hit[IX_VADR]),
      .rd_stat  (rd_hit[IX_STAT]),
      .data_acc (data_acc),
      .big_step (ctrl_q[2]),
      .d        (bus_wdata),
      .v        (v_addr),
      .t        (t_addr),
      .fx       (fine_x)
   );

   always_ff @(posedge clk) begin
      if (pwr_up) begin
         ctrl_q     <= '0;
         mask_q     <= '0;
         rbuf       <= '0;
         oam_addr_q <= warm ? WARM_OAM_ADDR : 8'h00;
      end else if (rst) begin
         ctrl_q <= '0;
         mask_q <= '0;
         rbuf   <= '0;
      end else begin
         if (wr_hit[IX_CTRL] && !warm_blk)
            ctrl_q <= bus_wdata;
         if (wr_hit[IX_MASK] && !warm_blk)
            mask_q <= bus_wdata;
         if (wr_hit[IX_OADR])
            oam_addr_q <= bus_wdata;
         else if (wr_hit[IX_ODAT])
            oam_addr_q <= oam_addr_q + 8'd1;
         if (rd_hit[IX_VDAT])
            rbuf <= vram_rdata;
      end
   end

   assign status_q = {flags.vbl, flags.spr0, flags.ovf, 5'b0};

   wire live = !pwr_up && !rst;
   assign oam_we     = wr_hit[IX_ODAT] && live;
   assign oam_wdata  = bus_wdata;
   assign vram_we    = wr_hit[IX_VDAT] && live;
   assign vram_wdata = bus_wdata;

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (reg_ix_e'(ix))
            IX_STAT: bus_rdata = status_q;
            IX_ODAT: bus_rdata = oam_rdata;
            IX_VDAT: bus_rdata = rbuf;
            default: bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/vreg_front_chk.sv
module vreg_front_chk #(
   parameter int ROW_STRIDE = 32
) (
   input logic        clk,
   input logic        pwr_up,
   input logic        rst,
   input logic        bus_wr,
   input logic        bus_rd,
   input logic [2:0]  ix,
   input logic        ev_vbl_start,
   input logic        ev_vbl_end,
   input logic        ev_spr0,
   input logic        ev_ovf,
   input logic        blk,
   input logic [7:0]  ctrl_q,
   input logic [7:0]  mask_q,
   input logic [7:0]  status_q,
   input logic [7:0]  oam_addr_q,
   input logic [14:0] v_addr,
   input logic [14:0] t_addr,
   input logic [2:0]  fine_x
);

   assert_block_ctrl_R4: assert property (@(posedge clk) disable iff (pwr_up)
      (blk && bus_wr && ix == 3'd0 && !rst) |=> ctrl_q == $past(ctrl_q));

   assert_block_scroll_R4: assert property (@(posedge clk) disable iff (pwr_up)
      (blk && bus_wr && (ix == 3'd5 || ix == 3'd6) && !rst)
      |=> (t_addr == $past(t_addr) && fine_x == $past(fine_x)));

   assert_flag_hold_R4: assert property (@(posedge clk) disable iff (pwr_up)
      (blk && !ev_vbl_end) |=> blk);

   assert_rst_arm_R4: assert property (@(posedge clk) disable iff (pwr_up)
      rst |=> blk);

   assert_rst_clear_R3: assert property (@(posedge clk) disable iff (pwr_up)
      rst |=> (ctrl_q == 8'h00 && mask_q == 8'h00 && t_addr == 15'h0 && fine_x == 3'd0));

   assert_rst_keep_R3: assert property (@(posedge clk) disable iff (pwr_up)
      rst |=> (v_addr == $past(v_addr) && oam_addr_q == $past(oam_addr_q)
               && status_q[7:5] == $past(status_q[7:5])));

   assert_stat_clear_R6: assert property (@(posedge clk) disable iff (pwr_up)
      (bus_rd && ix == 3'd2 && !ev_vbl_start && !rst) |=> !status_q[7]);

   assert_vend_clear_R6: assert property (@(posedge clk) disable iff (pwr_up)
      (ev_vbl_end && !ev_vbl_start && !ev_spr0 && !ev_ovf && !rst)
      |=> status_q[7:5] == 3'b000);

   assert_vstep_R11: assert property (@(posedge clk) disable iff (pwr_up)
      (bus_rd && ix == 3'd7 && !rst)
      |=> v_addr == $past(v_addr) + ($past(ctrl_q[2]) ? 15'(ROW_STRIDE) : 15'd1));

endmodule

bind vreg_front vreg_front_chk #(.ROW_STRIDE(ROW_STRIDE)) u_chk (
   .clk          (clk),
   .pwr_up       (pwr_up),
   .rst          (rst),
   .bus_wr       (bus_wr),
   .bus_rd       (bus_rd),
   .ix           (ix),
   .ev_vbl_start (ev_vbl_start),
   .ev_vbl_end   (ev_vbl_end),
   .ev_spr0      (ev_spr0),
   .ev_ovf       (ev_ovf),
   .blk          (warm_blk),
   .ctrl_q       (ctrl_q),
   .mask_q       (mask_q),
   .status_q     (status_q),
   .oam_addr_q   (oam_addr_q),
   .v_addr       (v_addr),
   .t_addr       (t_addr),
   .fine_x       (fine_x)
);

// File: tb/vreg_front_tb.sv
module vreg_front_tb;

   localparam int CLK_P = 10;

   logic        clk = 0;
   logic        pwr_up = 1, warm = 0, vbl_seed = 1, rst = 0;
   logic [12:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_wr = 0, bus_rd = 0;
   logic [7:0]  bus_rdata;
   logic        ev_vbl_start = 0, ev_vbl_end = 0, ev_spr0 = 0, ev_ovf = 0;
   logic [7:0]  oam_addr_q, oam_wdata, oam_rdata, vram_wdata, vram_rdata;
   logic        oam_we, vram_we;
   logic [7:0]  ctrl_q, mask_q, status_q;
   logic [14:0] v_addr, t_addr;
   logic [2:0]  fine_x;

   int total = 0, bad = 0;
   bit done = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       seen_vwe, seen_owe;
   logic [7:0] seen_vwd, seen_owd;

   always #(CLK_P/2) clk = ~clk;

   assign vram_rdata = v_addr[7:0] ^ 8'hA5;
   assign oam_rdata  = oam_addr_q ^ 8'h3C;

   vreg_front u_dut (
      .clk(clk), .pwr_up(pwr_up), .warm(warm), .vbl_seed(vbl_seed), .rst(rst),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata), .ev_vbl_start(ev_vbl_start), .ev_vbl_end(ev_vbl_end),
      .ev_spr0(ev_spr0), .ev_ovf(ev_ovf), .oam_addr_q(oam_addr_q), .oam_we(oam_we),
      .oam_wdata(oam_wdata), .oam_rdata(oam_rdata), .vram_we(vram_we),
      .vram_wdata(vram_wdata), .vram_rdata(vram_rdata), .ctrl_q(ctrl_q),
      .mask_q(mask_q), .status_q(status_q), .v_addr(v_addr), .t_addr(t_addr),
      .fine_x(fine_x)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // monitor: pops the expected read value while a read is on the bus
   always @(negedge clk) begin
      if (bus_rd && !done) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R13 unexpected read act=%h exp=none", bus_rdata);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string      s = tag_q.pop_front();
            chk(s, bus_rdata, e);
         end
      end
   end

   task automatic rd(input logic [12:0] a, input logic [7:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(posedge clk); #1;
      bus_addr = a; bus_rd = 1;
      @(posedge clk); #1;
      bus_rd = 0;
   endtask

   task automatic wr(input logic [12:0] a, input logic [7:0] d, input bit with_end = 0);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_wr = 1; ev_vbl_end = with_end;
      @(negedge clk);
      seen_vwe = vram_we; seen_vwd = vram_wdata;
      seen_owe = oam_we;  seen_owd = oam_wdata;
      @(posedge clk); #1;
      bus_wr = 0; ev_vbl_end = 0;
   endtask

   task automatic pulse(input int which);
      @(posedge clk); #1;
      case (which)
         0: ev_vbl_start = 1;
         1: ev_vbl_end = 1;
         2: ev_spr0 = 1;
         3: ev_ovf = 1;
         default: rst = 1;
      endcase
      @(posedge clk); #1;
      ev_vbl_start = 0; ev_vbl_end = 0; ev_spr0 = 0; ev_ovf = 0; rst = 0;
   endtask

   task automatic power(input bit w);
      @(posedge clk); #1;
      pwr_up = 1; warm = w;
      repeat (2) @(posedge clk);
      #1; pwr_up = 0; warm = 0;
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog all-R act=hung exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      // cold power-up with blank seed 1
      repeat (2) @(posedge clk);
      #1; pwr_up = 0;
      chk("R1 ctrl", ctrl_q, 8'h00);
      chk("R1 mask", mask_q, 8'h00);
      chk("R1 v", v_addr, 15'h0000);
      chk("R1 t", t_addr, 15'h0000);
      chk("R1 fx", fine_x, 0);
      chk("R1 oam", oam_addr_q, 8'h00);
      chk("R1 status seed", status_q, 8'h80);
      rd(13'h0002, 8'h80, "R6 status read");
      rd(13'h0002, 8'h00, "R6 blank cleared by read");

      // warmup: guarded writes dropped, others live
      wr(13'h0000, 8'hFF);
      chk("R4 ctrl blocked", ctrl_q, 8'h00);
      wr(13'h0005, 8'h7D);
      chk("R4 scroll blocked t", t_addr, 15'h0000);
      chk("R4 scroll blocked fx", fine_x, 0);
      wr(13'h0003, 8'h10);
      chk("R5 oam addr in warmup", oam_addr_q, 8'h10);
      wr(13'h0004, 8'h55);
      chk("R5 R12 oam we", seen_owe, 1);
      chk("R12 oam wdata", seen_owd, 8'h55);
      chk("R12 oam addr step", oam_addr_q, 8'h11);
      wr(13'h0007, 8'h9C);
      chk("R5 R11 vram we", seen_vwe, 1);
      chk("R11 vram wdata", seen_vwd, 8'h9C);
      chk("R11 v step 1", v_addr, 15'h0001);

      // write during the end pulse is still dropped; then unblocked
      wr(13'h0000, 8'h04, 1);
      chk("R4 write with end dropped", ctrl_q, 8'h00);
      wr(13'h0001, 8'h1E);
      chk("R9 mask stored", mask_q, 8'h1E);

      // address pairs (toggle held through the blocked scroll write)
      wr(13'h0006, 8'h21);
      chk("R8 first half t", t_addr, 15'h2100);
      chk("R8 v untouched", v_addr, 15'h0001);
      wr(13'h0006, 8'h08);
      chk("R4 R8 second half v", v_addr, 15'h2108);

      // scroll fields
      wr(13'h0005, 8'h7D);
      chk("R7 first t", t_addr, 15'h210F);
      chk("R7 fine x", fine_x, 5);
      wr(13'h0005, 8'h5E);
      chk("R7 second t", t_addr, 15'h616F);
      chk("R7 v kept", v_addr, 15'h2108);
      wr(13'h0000, 8'h03);
      chk("R9 ctrl stored", ctrl_q, 8'h03);
      chk("R9 t nametable bits", t_addr, 15'h6D6F);

      // buffered data reads and strides
      rd(13'h0007, 8'h00, "R10 first read old buffer");
      rd(13'h0007, 8'hAD, "R10 second read");
      chk("R11 v after two reads", v_addr, 15'h210A);
      wr(13'h0000, 8'h04);
      rd(13'h0007, 8'hAC, "R10 third read");
      chk("R11 stride 32 read", v_addr, 15'h212A);
      wr(13'h0007, 8'h11);
      chk("R11 stride 32 write", v_addr, 15'h214A);

      // status read clears the toggle
      wr(13'h0006, 8'h3F);
      rd(13'h0002, 8'h00, "R6 status idle");
      wr(13'h0006, 8'h3F);
      wr(13'h0006, 8'h00);
      chk("R6 toggle cleared by read", v_addr, 15'h3F00);

      // flag pulses
      pulse(2); pulse(3); pulse(0);
      rd(13'h0002, 8'hE0, "R6 all flags");
      rd(13'h0002, 8'h60, "R6 blank only cleared");
      pulse(1);
      rd(13'h0002, 8'h00, "R6 end clears flags");

      // console reset
      pulse(0);
      rd(13'h0007, 8'hAF, "R10 pre-reset read");
      wr(13'h0006, 8'h12);
      pulse(4);
      chk("R3 ctrl", ctrl_q, 8'h00);
      chk("R3 mask", mask_q, 8'h00);
      chk("R3 t", t_addr, 15'h0000);
      chk("R3 v kept", v_addr, 15'h3F20);
      chk("R3 oam kept", oam_addr_q, 8'h11);
      chk("R3 status kept", status_q, 8'h80);
      rd(13'h0007, 8'h00, "R3 buffer cleared");
      chk("R3 R11 stride back to 1", v_addr, 15'h3F21);
      wr(13'h0001, 8'h1E);
      chk("R4 mask blocked after reset", mask_q, 8'h00);
      pulse(1);
      wr(13'h0006, 8'h12);
      wr(13'h0006, 8'h34);
      chk("R3 toggle cleared by reset", v_addr, 15'h1234);
      chk("R6 end cleared blank", status_q, 8'h00);

      // mirrored decode
      wr(13'h1FFB, 8'h44);
      chk("R13 mirrored oam addr", oam_addr_q, 8'h44);
      rd(13'h080C, 8'h78, "R12 R13 oam data read");
      chk("R12 no step on read", oam_addr_q, 8'h44);
      rd(13'h1000, 8'h00, "R13 write-only reads zero");
      rd(13'h0A0E, 8'h00, "R13 vaddr reads zero");

      // warm power-up
      power(1);
      chk("R2 status", status_q, 8'h80);
      chk("R2 v", v_addr, 15'h0001);
      chk("R2 oam", oam_addr_q, 8'h2F);
      chk("R2 t", t_addr, 15'h0000);
      wr(13'h0000, 8'hFF);
      chk("R2 R4 ctrl blocked", ctrl_q, 8'h00);

      repeat (2) @(posedge clk);
      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL R10 reads pending act=%0d exp=0", exp_q.size());
      end
      done = 1;
      summary();
      $finish;
   end

endmodule